// File: doc/BRIEF.md
# Transport Stream PID Bitmap Filter

This block removes unwanted packets from two independent MPEG transport streams. Every stream owns a drop bitmap with one bit per 13-bit packet identifier (PID). A set bit discards every packet that carries that identifier, and a clear bit lets those packets through. Identifiers below 0x20 are never filtered, whatever their bitmap bit holds. Each stream arrives as a byte stream with a valid strobe and a start-of-packet flag. The block sends out the same stream with the discarded packets cut out whole, from the sync byte to the last byte.

The identifier sits in packet bytes 1 and 2. The block holds bytes 0 and 1 back and decides when byte 2 arrives. A packet that passes then goes into a small output queue three bytes at once, and the later bytes follow one per beat. The host loads the bitmaps through a narrow register port. Two registers select a byte of the bitmap and the stream it belongs to, and a data register reads or writes the selected byte. The bitmap byte index is PID bits 12..3 and the bit within that byte is PID bits 2..0. Loading 0xFF into every byte of a stream blocks the whole stream apart from the low identifiers, and loading 0x00 passes the complete stream.

Top module: `pid_bitmap_filter`

## Requirements
- R1: After reset no stream output is valid, the index and stream-select registers read 0, and `reg_rdata` is 0.
- R2: Register 0x8 holds byte-index bits 7..0. Register 0x9 holds byte-index bits 9..8 in its bits 1:0 and the stream select in bit 2, and its other bits read 0. Every other address reads 0 and ignores writes. Read data appears in the cycle after `reg_rd` and holds until the next read.
- R3: A write to register 0xA stores the byte at the selected stream and index. A read of 0xA returns that stored byte.
- R4: The PID is {byte1[4:0], byte2}. A packet is dropped when bit PID[2:0] of bitmap byte PID[12:3] of its own stream is 1, and passed when that bit is 0.
- R5: A packet whose PID is below 0x20 always passes, even when its bitmap bit is 1.
- R6: A passed packet leaves the block complete and in order, with `ts_out_sop` on its first byte. No byte of a dropped packet, sync byte included, appears at the output.
- R7: Each stream is filtered only by its own bitmap. Traffic and bitmap contents of one stream have no effect on the other.
- R8: The pass/drop decision reads the bitmap in the cycle byte 2 is accepted. A bitmap write accepted in an earlier cycle affects that packet. A write in the same cycle or later affects only later packets and never cuts a packet short.
- R9: Bytes that arrive while no packet is open are discarded. This covers bytes before the first start-of-packet and bytes beyond the packet length. A start-of-packet flag abandons an unfinished packet, and a packet abandoned before its byte 2 emits nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after `reg_rd` |
| ts_in_valid | input | NSTR | Input byte valid, one bit per stream |
| ts_in_sop | input | NSTR | Input start of packet, one bit per stream |
| ts_in_data | input | NSTR*8 | Input bytes, stream s at bits s*8 +: 8 |
| ts_out_valid | output | NSTR | Output byte valid, one bit per stream |
| ts_out_sop | output | NSTR | Output start of packet, one bit per stream |
| ts_out_data | output | NSTR*8 | Output bytes, stream s at bits s*8 +: 8 |

## Verification
A host write to a bitmap byte can land in the same clock cycle as a packet's identifier lookup that reads the same byte. The bench provokes this by putting a data-register write on the same edge as byte 2 of a packet whose drop bit the write sets. It then repeats the write one edge earlier, on byte 1. It judges each case by the number of bytes that stream emits: all of them when the write shares the lookup edge, and none when the write came first. A follow-up packet with the same identifier must then be dropped in full.

// File: rtl/pidf_pkg.sv
package pidf_pkg;

    // Identifier geometry: byte index is the upper bits, bit select the lower three
    localparam int PID_W       = 13;
    localparam int BIT_W       = 3;
    localparam int IDX_W       = PID_W - BIT_W;
    localparam int IDX_LO_W    = 8;
    localparam int IDX_HI_W    = IDX_W - IDX_LO_W;
    localparam int BM_DEPTH    = 1 << IDX_W;
    localparam int FORCED_PASS = 32;

    // Host register addresses and the stream-select position in the high index register
    localparam int REG_IDX_LO  = 8;
    localparam int REG_IDX_HI  = 9;
    localparam int REG_DATA    = 10;
    localparam int SEL_POS     = 2;

    typedef logic [PID_W-1:0] pid_t;

    typedef struct packed {
        logic       sop;
        logic [7:0] data;
    } ts_beat_t;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_IDX_LO,
        RG_IDX_HI,
        RG_DATA
    } reg_sel_e;

    function automatic reg_sel_e reg_decode(input logic [7:0] a);
        case (a)
            8'(REG_IDX_LO): return RG_IDX_LO;
            8'(REG_IDX_HI): return RG_IDX_HI;
            8'(REG_DATA):   return RG_DATA;
            default:        return RG_NONE;
        endcase
    endfunction

    function automatic pid_t pid_join(input logic [4:0] hi, input logic [7:0] lo);
        return {hi, lo};
    endfunction

    function automatic logic pid_forced(input pid_t p);
        return p < pid_t'(FORCED_PASS);
    endfunction

    function automatic logic [IDX_W-1:0] pid_byte_index(input pid_t p);
        return p[PID_W-1:BIT_W];
    endfunction

    function automatic logic [BIT_W-1:0] pid_bit(input pid_t p);
        return p[BIT_W-1:0];
    endfunction

endpackage

// File: rtl/pidf_host_regs.sv
module pidf_host_regs
    import pidf_pkg::*;
#(
    parameter int NSTR  = 2,
    parameter int AW    = 4,
    parameter int SEL_W = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [AW-1:0]       reg_addr,
    input  logic [7:0]          reg_wdata,
    input  logic [NSTR*8-1:0]   bm_bytes,
    output logic [IDX_W-1:0]    idx,
    output logic [SEL_W-1:0]    sel,
    output logic                bm_we,
    output logic [7:0]          reg_rdata
);

    reg_sel_e           dec;
    logic [IDX_W-1:0]   idx_q;
    logic [SEL_W-1:0]   sel_q;
    logic [7:0]         rdata_q;
    logic [7:0]         rd_mux;
    logic [7:0]         hi_view;

    assign dec   = reg_decode(8'(reg_addr));
    assign bm_we = reg_wr && (dec == RG_DATA);
    assign idx   = idx_q;
    assign sel   = sel_q;

    always_comb begin
        hi_view = '0;
        hi_view[IDX_HI_W-1:0]     = idx_q[IDX_W-1:IDX_LO_W];
        hi_view[SEL_POS +: SEL_W] = sel_q;
    end

    always_comb begin
        case (dec)
            RG_IDX_LO: rd_mux = idx_q[IDX_LO_W-1:0];
            RG_IDX_HI: rd_mux = hi_view;
            RG_DATA:   rd_mux = bm_bytes[int'(sel_q)*8 +: 8];
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            sel_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (reg_wr) begin
                if (dec == RG_IDX_LO) begin
                    idx_q[IDX_LO_W-1:0] <= reg_wdata;
                end
                if (dec == RG_IDX_HI) begin
                    idx_q[IDX_W-1:IDX_LO_W] <= reg_wdata[IDX_HI_W-1:0];
                    sel_q                   <= reg_wdata[SEL_POS +: SEL_W];
                end
            end
            if (reg_rd) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign reg_rdata = rdata_q;

endmodule

// File: rtl/pidf_bitmap.sv
module pidf_bitmap
    import pidf_pkg::*;
#(
    parameter int DEPTH = BM_DEPTH
) (
    input  logic               clk,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  logic [7:0]         wdata,
    output logic [7:0]         host_rdata,
    input  logic [IDX_W-1:0]   look_idx,
    output logic [7:0]         look_byte
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Both reads see the contents as they stand before the current edge
    assign host_rdata = mem[widx];
    assign look_byte  = mem[look_idx];

endmodule

// File: rtl/pidf_gate.sv
module pidf_gate
    import pidf_pkg::*;
#(
    parameter int PKT_LEN    = 188,
    parameter int HOLD_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic [7:0]         in_data,
    output logic [IDX_W-1:0]   look_idx,
    input  logic [7:0]         look_byte,
    output logic               out_valid,
    output logic               out_sop,
    output logic [7:0]         out_data
);

    localparam int POS_W = $clog2(PKT_LEN);
    localparam int CNT_W = $clog2(HOLD_DEPTH + 1);

    logic               open_q, open_d;
    logic [POS_W-1:0]   pos_q, pos_d;
    logic               keep_q, keep_d;
    logic [7:0]         b0_q, b0_d;
    logic [7:0]         b1_q, b1_d;
    ts_beat_t           q_q [HOLD_DEPTH];
    ts_beat_t           q_d [HOLD_DEPTH];
    logic [CNT_W-1:0]   cnt_q, cnt_d;

    ts_beat_t           push [3];
    int                 push_n;
    pid_t               pid_w;
    logic               pid_drop;

    assign pid_w    = pid_join(b1_q[4:0], in_data);
    assign look_idx = pid_byte_index(pid_w);
    assign pid_drop = !pid_forced(pid_w) && look_byte[pid_bit(pid_w)];

    // Packet framing and the pass/drop decision at byte 2
    always_comb begin
        open_d = open_q;
        pos_d  = pos_q;
        keep_d = keep_q;
        b0_d   = b0_q;
        b1_d   = b1_q;
        push_n = 0;
        for (int k = 0; k < 3; k++) begin
            push[k] = '0;
        end
        if (in_valid) begin
            if (in_sop) begin
                open_d = 1'b1;
                pos_d  = POS_W'(1);
                keep_d = 1'b0;
                b0_d   = in_data;
            end else if (open_q) begin
                if (pos_q == POS_W'(1)) begin
                    b1_d = in_data;
                end else if (pos_q == POS_W'(2)) begin
                    keep_d = !pid_drop;
                    if (!pid_drop) begin
                        push_n  = 3;
                        push[0] = '{sop: 1'b1, data: b0_q};
                        push[1] = '{sop: 1'b0, data: b1_q};
                        push[2] = '{sop: 1'b0, data: in_data};
                    end
                end else if (keep_q) begin
                    push_n  = 1;
                    push[0] = '{sop: 1'b0, data: in_data};
                end
                pos_d = pos_q + POS_W'(1);
                if (pos_q == POS_W'(PKT_LEN - 1)) begin
                    open_d = 1'b0;
                end
            end
        end
    end

    // Output queue: one pop per cycle, up to three pushes
    always_comb begin
        logic pop;
        int   base;
        pop  = (cnt_q != '0);
        base = int'(cnt_q) - (pop ? 1 : 0);
        for (int i = 0; i < HOLD_DEPTH - 1; i++) begin
            q_d[i] = pop ? q_q[i+1] : q_q[i];
        end
        q_d[HOLD_DEPTH-1] = pop ? '0 : q_q[HOLD_DEPTH-1];
        for (int k = 0; k < 3; k++) begin
            if (k < push_n && base + k < HOLD_DEPTH) begin
                q_d[base + k] = push[k];
            end
        end
        cnt_d = CNT_W'(base + push_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            pos_q  <= '0;
            keep_q <= 1'b0;
            b0_q   <= '0;
            b1_q   <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < HOLD_DEPTH; i++) begin
                q_q[i] <= '0;
            end
        end else begin
            open_q <= open_d;
            pos_q  <= pos_d;
            keep_q <= keep_d;
            b0_q   <= b0_d;
            b1_q   <= b1_d;
            cnt_q  <= cnt_d;
            for (int i = 0; i < HOLD_DEPTH; i++) begin
                q_q[i] <= q_d[i];
            end
        end
    end

    assign out_valid = (cnt_q != '0);
    assign out_sop   = out_valid && q_q[0].sop;
    assign out_data  = q_q[0].data;

endmodule

// File: rtl/pid_bitmap_filter.sv
module pid_bitmap_filter
    import pidf_pkg::*;
#(
    parameter int NSTR       = 2,
    parameter int PKT_LEN    = 188,
    parameter int HOLD_DEPTH = 4,
    parameter int AW         = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [AW-1:0]       reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [NSTR-1:0]     ts_in_valid,
    input  logic [NSTR-1:0]     ts_in_sop,
    input  logic [NSTR*8-1:0]   ts_in_data,
    output logic [NSTR-1:0]     ts_out_valid,
    output logic [NSTR-1:0]     ts_out_sop,
    output logic [NSTR*8-1:0]   ts_out_data
);

    localparam int SEL_W = (NSTR > 1) ? $clog2(NSTR) : 1;

    logic [IDX_W-1:0]   h_idx;
    logic [SEL_W-1:0]   h_sel;
    logic               h_we;
    logic [NSTR*8-1:0]  h_bytes;

    pidf_host_regs #(
        .NSTR  (NSTR),
        .AW    (AW),
        .SEL_W (SEL_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .bm_bytes  (h_bytes),
        .idx       (h_idx),
        .sel       (h_sel),
        .bm_we     (h_we),
        .reg_rdata (reg_rdata)
    );

    for (genvar s = 0; s < NSTR; s++) begin : g_stream
        logic [IDX_W-1:0] look_idx;
        logic [7:0]       look_byte;
        logic             we_s;

        assign we_s = h_we && (h_sel == SEL_W'(s));

        pidf_bitmap #(
            .DEPTH (BM_DEPTH)
        ) u_bm (
            .clk        (clk),
            .we         (we_s),
            .widx       (h_idx),
            .wdata      (reg_wdata),
            .host_rdata (h_bytes[s*8 +: 8]),
            .look_idx   (look_idx),
            .look_byte  (look_byte)
        );

        pidf_gate #(
            .PKT_LEN    (PKT_LEN),
            .HOLD_DEPTH (HOLD_DEPTH)
        ) u_gate (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (ts_in_valid[s]),
            .in_sop    (ts_in_sop[s]),
            .in_data   (ts_in_data[s*8 +: 8]),
            .look_idx  (look_idx),
            .look_byte (look_byte),
            .out_valid (ts_out_valid[s]),
            .out_sop   (ts_out_sop[s]),
            .out_data  (ts_out_data[s*8 +: 8])
        );
    end

endmodule

// File: rtl/pidf_checker.sv
module pidf_checker
    import pidf_pkg::*;
#(
    parameter int AW   = 4,
    parameter int NSTR = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [AW-1:0]    reg_addr,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input logic [NSTR-1:0]  ts_out_valid,
    input logic [NSTR-1:0]  ts_out_sop
);

    logic mapped;
    assign mapped = (reg_addr == AW'(REG_IDX_LO)) || (reg_addr == AW'(REG_IDX_HI))
                 || (reg_addr == AW'(REG_DATA));

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ts_out_valid == '0));                               // R1

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !mapped) |=> (reg_rdata == 8'h00));                      // R2

    AST_DATA_READBACK: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == AW'(REG_DATA)) ##1
        (reg_rd && !reg_wr && reg_addr == AW'(REG_DATA))
        |=> (reg_rdata == $past(reg_wdata, 2)));                            // R3

    for (genvar s = 0; s < NSTR; s++) begin : g_chk
        AST_SOP_HEAD_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
            (ts_out_valid[s] && ts_out_sop[s]) |=> ts_out_valid[s]);         // R6
    end

endmodule

bind pid_bitmap_filter pidf_checker #(
    .AW   (AW),
    .NSTR (NSTR)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .ts_out_valid (ts_out_valid),
    .ts_out_sop   (ts_out_sop)
);

// File: tb/sim_pid_bitmap_filter.sv
module sim_pid_bitmap_filter;

    localparam int AW   = 4;
    localparam int NSTR = 2;
    localparam int PKT  = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               reg_wr = 1'b0;
    logic               reg_rd = 1'b0;
    logic [AW-1:0]      reg_addr = '0;
    logic [7:0]         reg_wdata = '0;
    logic [7:0]         reg_rdata;
    logic [NSTR-1:0]    ts_in_valid = '0;
    logic [NSTR-1:0]    ts_in_sop = '0;
    logic [NSTR*8-1:0]  ts_in_data = '0;
    logic [NSTR-1:0]    ts_out_valid;
    logic [NSTR-1:0]    ts_out_sop;
    logic [NSTR*8-1:0]  ts_out_data;

    always #2.5 clk = ~clk;

    pid_bitmap_filter #(
        .NSTR       (NSTR),
        .PKT_LEN    (PKT),
        .HOLD_DEPTH (4),
        .AW         (AW)
    ) u0 (
        .clk          (clk),
        .rst          (rst),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .ts_in_valid  (ts_in_valid),
        .ts_in_sop    (ts_in_sop),
        .ts_in_data   (ts_in_data),
        .ts_out_valid (ts_out_valid),
        .ts_out_sop   (ts_out_sop),
        .ts_out_data  (ts_out_data)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    int          out_cnt [2] = '{0, 0};
    logic [8:0]  exp0 [$];
    logic [8:0]  exp1 [$];
    logic [7:0]  model [2][1024];
    logic [8:0]  mon_act;
    logic [8:0]  mon_exp;
    bit          finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Reference model of the filter decision
    function automatic bit exp_pass(input int s, input int pid);
        if (pid < 32) return 1'b1;
        return model[s][pid >> 3][pid & 7] == 1'b0;
    endfunction

    function automatic logic [7:0] pkt_byte(input int pid, input int k);
        if (k == 0) return 8'h47;
        if (k == 1) return {3'b010, 5'(pid >> 8)};
        if (k == 2) return 8'(pid);
        return 8'(pid * 3 + k);
    endfunction

    function automatic logic [7:0] pattern(input int s, input int i);
        return 8'(i * 37 + s * 91 + 5);
    endfunction

    // Output monitor, sampled between edges
    always @(negedge clk) begin
        if (!rst) begin
            for (int s = 0; s < 2; s++) begin
                if (ts_out_valid[s]) begin
                    mon_act = {ts_out_sop[s], ts_out_data[s*8 +: 8]};
                    out_cnt[s]++;
                    if ((s == 0 && exp0.size() == 0) || (s == 1 && exp1.size() == 0)) begin
                        chk(1'b0, "R6", $sformatf("unexpected beat on stream %0d", s),
                            int'(mon_act), 0);
                    end else begin
                        mon_exp = (s == 0) ? exp0.pop_front() : exp1.pop_front();
                        chk(mon_act == mon_exp, "R6", $sformatf("beat on stream %0d", s),
                            int'(mon_act), int'(mon_exp));
                    end
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "R6", "watchdog expired", 0, 1);
        finish_run();
    end

    task automatic reg_write(input int a, input logic [7:0] d);
        reg_wr    = 1'b1;
        reg_addr  = AW'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, output logic [7:0] d);
        reg_rd   = 1'b1;
        reg_addr = AW'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic bm_write(input int s, input int idx, input logic [7:0] v);
        reg_write(9, 8'((s << 2) | (idx >> 8)));
        reg_write(8, 8'(idx));
        reg_write(10, v);
        model[s][idx] = v;
    endtask

    // mode 0: arithmetic pattern, 1: all ones, 2: all zeros
    task automatic fill(input int s, input int mode);
        for (int i = 0; i < 1024; i++) begin
            logic [7:0] v;
            v = (mode == 0) ? pattern(s, i) : ((mode == 1) ? 8'hFF : 8'h00);
            if ((i & 255) == 0) reg_write(9, 8'((s << 2) | (i >> 8)));
            reg_write(8, 8'(i));
            reg_write(10, v);
            model[s][i] = v;
        end
    endtask

    task automatic drive_beat(input int s, input bit sop, input logic [7:0] d);
        ts_in_valid[s]       = 1'b1;
        ts_in_sop[s]         = sop;
        ts_in_data[s*8 +: 8] = d;
        @(negedge clk);
    endtask

    task automatic idle(input int s);
        ts_in_valid[s] = 1'b0;
        ts_in_sop[s]   = 1'b0;
    endtask

    task automatic push_exp(input int s, input int pid);
        for (int k = 0; k < PKT; k++) begin
            if (s == 0) exp0.push_back({k == 0, pkt_byte(pid, k)});
            else        exp1.push_back({k == 0, pkt_byte(pid, k)});
        end
    endtask

    task automatic send_pkt(input int s, input int pid, input bit gap);
        if (exp_pass(s, pid)) push_exp(s, pid);
        for (int k = 0; k < PKT; k++) begin
            drive_beat(s, k == 0, pkt_byte(pid, k));
            if (gap) begin
                idle(s);
                @(negedge clk);
            end
        end
        idle(s);
    endtask

    task automatic drain();
        repeat (8) @(negedge clk);
    endtask

    initial begin
        logic [7:0] rd;
        int         c;
        int         pid_p;
        int         idx_p;
        int         free_pid;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(ts_out_valid == '0, "R1", "outputs idle after reset", int'(ts_out_valid), 0);
        chk(reg_rdata == 8'h00, "R1", "read data after reset", int'(reg_rdata), 0);
        reg_read(8, rd);
        chk(rd == 8'h00, "R1", "index low after reset", int'(rd), 0);
        reg_read(9, rd);
        chk(rd == 8'h00, "R1", "index high after reset", int'(rd), 0);

        // R2: register map and ignored addresses
        reg_write(8, 8'hA5);
        reg_write(9, 8'hFF);
        reg_read(9, rd);
        chk(rd == 8'h07, "R2", "index high readback", int'(rd), 8'h07);
        reg_write(3, 8'h55);
        reg_write(11, 8'h00);
        reg_read(8, rd);
        chk(rd == 8'hA5, "R2", "index low after unmapped writes", int'(rd), 8'hA5);
        reg_read(9, rd);
        chk(rd == 8'h07, "R2", "index high after unmapped writes", int'(rd), 8'h07);
        reg_read(3, rd);
        chk(rd == 8'h00, "R2", "unmapped read", int'(rd), 0);
        reg_read(15, rd);
        chk(rd == 8'h00, "R2", "unmapped read top", int'(rd), 0);

        // R3: load both bitmaps and read a spread of bytes back
        fill(0, 0);
        fill(1, 0);
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 1024; i += 3) begin
                reg_write(9, 8'((s << 2) | (i >> 8)));
                reg_write(8, 8'(i));
                reg_read(10, rd);
                chk(rd == pattern(s, i), "R3", $sformatf("bitmap %0d byte %0d", s, i),
                    int'(rd), int'(pattern(s, i)));
            end
        end

        // R4, R5, R7: every identifier on both streams at once, distinct bitmaps
        fork
            for (int p = 0; p < 8192; p++) send_pkt(0, p, (p % 13) == 0);
            for (int p = 0; p < 8192; p++) send_pkt(1, p, (p % 11) == 0);
        join
        drain();
        chk(exp0.size() == 0, "R4", "stream 0 sweep fully delivered", exp0.size(), 0);
        chk(exp1.size() == 0, "R7", "stream 1 sweep fully delivered", exp1.size(), 0);

        // R8: bitmap write in the same cycle as the lookup is not seen
        pid_p = 16'h0123;
        idx_p = pid_p >> 3;
        bm_write(1, idx_p, model[1][idx_p] & ~8'(1 << (pid_p & 7)));
        c = out_cnt[1];
        push_exp(1, pid_p);
        drive_beat(1, 1'b1, pkt_byte(pid_p, 0));
        drive_beat(1, 1'b0, pkt_byte(pid_p, 1));
        reg_wr    = 1'b1;
        reg_addr  = AW'(10);
        reg_wdata = model[1][idx_p] | 8'(1 << (pid_p & 7));
        drive_beat(1, 1'b0, pkt_byte(pid_p, 2));
        reg_wr = 1'b0;
        model[1][idx_p] = reg_wdata;
        for (int k = 3; k < PKT; k++) drive_beat(1, 1'b0, pkt_byte(pid_p, k));
        idle(1);
        drain();
        chk(out_cnt[1] - c == PKT, "R8", "same-cycle write leaves packet whole",
            out_cnt[1] - c, PKT);
        c = out_cnt[1];
        send_pkt(1, pid_p, 1'b0);
        drain();
        chk(out_cnt[1] - c == 0, "R8", "next packet sees the write", out_cnt[1] - c, 0);

        // R8: write one cycle ahead of the lookup takes effect
        bm_write(1, idx_p, model[1][idx_p] & ~8'(1 << (pid_p & 7)));
        c = out_cnt[1];
        drive_beat(1, 1'b1, pkt_byte(pid_p, 0));
        reg_wr    = 1'b1;
        reg_addr  = AW'(10);
        reg_wdata = model[1][idx_p] | 8'(1 << (pid_p & 7));
        drive_beat(1, 1'b0, pkt_byte(pid_p, 1));
        reg_wr = 1'b0;
        model[1][idx_p] = reg_wdata;
        for (int k = 2; k < PKT; k++) drive_beat(1, 1'b0, pkt_byte(pid_p, k));
        idle(1);
        drain();
        chk(out_cnt[1] - c == 0, "R8", "earlier write drops packet", out_cnt[1] - c, 0);

        // R5: block everything on stream 0
        fill(0, 1);
        for (int j = 0; j < 5; j++) begin
            int p;
            p = (j == 0) ? 0 : (j == 1) ? 16'h1F : (j == 2) ? 16'h20 : (j == 3) ? 16'h1FFF : 16'h0ABC;
            c = out_cnt[0];
            send_pkt(0, p, 1'b0);
            drain();
            chk(out_cnt[0] - c == ((p < 32) ? PKT : 0), "R5",
                $sformatf("all-ones bitmap, pid 0x%0h", p), out_cnt[0] - c, (p < 32) ? PKT : 0);
        end

        // R7: stream 1 unaffected by stream 0 blocking everything
        free_pid = 32;
        while (!exp_pass(1, free_pid)) free_pid++;
        c = out_cnt[1];
        send_pkt(1, free_pid, 1'b0);
        drain();
        chk(out_cnt[1] - c == PKT, "R7", "stream 1 still passes its clear pid",
            out_cnt[1] - c, PKT);

        // R4: pass-all bitmap
        fill(0, 2);
        c = out_cnt[0];
        send_pkt(0, 16'h20, 1'b0);
        send_pkt(0, 16'h1FFF, 1'b1);
        drain();
        chk(out_cnt[0] - c == 2 * PKT, "R4", "all-zero bitmap passes", out_cnt[0] - c, 2 * PKT);

        // R9: stray bytes, abandoned packet, overlong packet
        c = out_cnt[0];
        drive_beat(0, 1'b0, 8'h11);
        drive_beat(0, 1'b0, 8'h22);
        drive_beat(0, 1'b0, 8'h33);
        idle(0);
        send_pkt(0, 16'h10, 1'b0);
        drive_beat(0, 1'b1, 8'h47);
        drive_beat(0, 1'b0, 8'h40);
        send_pkt(0, 16'h11, 1'b0);
        send_pkt(0, 16'h12, 1'b0);
        drive_beat(0, 1'b0, 8'h99);
        drive_beat(0, 1'b0, 8'h98);
        idle(0);
        drain();
        chk(out_cnt[0] - c == 3 * PKT, "R9", "only framed packets emitted",
            out_cnt[0] - c, 3 * PKT);

        drain();
        chk(exp0.size() == 0, "R6", "stream 0 nothing outstanding", exp0.size(), 0);
        chk(exp1.size() == 0, "R6", "stream 1 nothing outstanding", exp1.size(), 0);
        finish_run();
    end

endmodule